// File: doc/BRIEF.md
# CPU Interrupt and Bus-Request Sequencer

This block is the event-recognition part of an 8-bit processor's cycle control. It watches the bus-request, non-maskable interrupt, maskable interrupt and wait inputs, and decides which event is serviced at each machine-cycle or instruction boundary. It drives the bus-acknowledge, halt and bus output-enable controls, and it hands a restart vector to the fetch logic whenever it accepts an interrupt. The interrupt-enable flip-flop and its shadow copy live here.

Instruction execution is represented by a fixed-length stub. Every machine cycle lasts `CYC_LEN` clocks, and every instruction lasts `MCYC_PER_INSTR` machine cycles. The stub produces the boundary strobes. Software effects that need decode are supplied as one-cycle input strobes: set, clear or restore the enable flip-flop, and mark the finishing instruction as a halt. The raw reset input is qualified: only a level held over two consecutive clock samples resets the block.

Priority is fixed. Bus request is taken at the end of any machine cycle. Both interrupts wait for the end of an instruction. The non-maskable interrupt ignores the enable flip-flop and restarts at 0x0066. The maskable interrupt restarts at `INT_VEC`, which defaults to 0x0038.

Top module: `irq_bus_sequencer`

## Requirements
- R1: Internal reset happens only when `rst_in` is sampled high at two consecutive rising edges. One edge later it gives `ie_out`=0, `ie_shadow`=0, `halt_n`=1, `busack_n`=1, `bus_oe`=1, `vec_load`=0, and it clears any latched non-maskable interrupt. A single-cycle high on `rst_in` changes none of these.
- R2: When `busreq_n` is low in a cycle with `mcycle_end`=1, `busack_n` goes to 0 and `bus_oe` goes to 0 at the next edge. While the grant lasts, `mcycle_end` and `instr_end` stay 0.
- R3: When `busreq_n` is high during a grant, `busack_n` and `bus_oe` both return to 1 one clock later. Machine cycles then resume.
- R4: At an instruction end where the bus request is taken, no interrupt is accepted. Interrupts are reconsidered at the next instruction end.
- R5: A high-to-low transition of `nmi_n` is latched. It is accepted at the next instruction end that takes no bus request, whatever `ie_out` is. One clock after acceptance, `vec_load` pulses for one cycle with `vec_addr`=0x0066. One transition gives exactly one acceptance.
- R6: When a non-maskable interrupt is latched at an instruction end, it is accepted in preference to a low `int_n`.
- R7: The maskable interrupt is accepted at an instruction end when `int_n` is low, `ie_out`=1, no bus request is taken and no non-maskable interrupt is latched. Acceptance gives a `vec_load` pulse with `vec_addr`=`INT_VEC` (0x0038). When `ie_out`=0, a low `int_n` gives no `vec_load`.
- R8: Accepting either interrupt clears `ie_out` at the next edge. A non-maskable acceptance first copies `ie_out` into `ie_shadow`. The strobes `ie_set`, `ie_clear` and `ie_restore` (shadow copied into `ie_out`) act at the next edge. An acceptance in the same cycle overrides them.
- R9: When `halt_op` is high at an instruction end that accepts no interrupt, `halt_n` goes low. It stays low until an interrupt is accepted, and it returns high on the same edge at which `vec_load` rises.
- R10: While `wait_n` is low, `mcycle_end` stays 0 and the machine cycle does not advance.
- R11: With no grant and no wait, `mcycle_end` pulses once every `CYC_LEN` (3) clocks, and `instr_end` coincides with every `MCYC_PER_INSTR`-th (2nd) one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Raw active-high reset, qualified over two samples |
| busreq_n | input | 1 | Bus request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, active low, edge latched |
| int_n | input | 1 | Maskable interrupt, active low, level |
| wait_n | input | 1 | Wait, active low, stalls the machine cycle |
| ie_set | input | 1 | Strobe: set the interrupt-enable flip-flop |
| ie_clear | input | 1 | Strobe: clear the interrupt-enable flip-flop |
| ie_restore | input | 1 | Strobe: copy the shadow bit into the enable flip-flop |
| halt_op | input | 1 | The instruction now finishing is a halt |
| busack_n | output | 1 | Bus grant acknowledge, active low |
| bus_oe | output | 1 | Output enable for address, data and control drivers |
| halt_n | output | 1 | Halted, active low |
| vec_load | output | 1 | One-cycle strobe: load `vec_addr` into the program counter |
| vec_addr | output | 16 | Restart vector of the accepted interrupt |
| mcycle_end | output | 1 | Machine-cycle boundary strobe |
| instr_end | output | 1 | Instruction boundary strobe |
| ie_out | output | 1 | Interrupt-enable flip-flop |
| ie_shadow | output | 1 | Shadow copy of the enable taken at non-maskable acceptance |

## Verification
The assertions assume that at most one of `ie_set`, `ie_clear` and `ie_restore` is high in a cycle, and that every input is a clean level synchronous to `clk`. The bench meets both assumptions. It draws the three strobes from a single random choice and changes every input only on the falling edge. Bus request is driven in held stretches, so grants and releases both occur. Non-maskable pulses and wait stretches are short, which keeps the boundaries coming and lets the halt state be both entered and left.

// File: rtl/evseq_pkg.sv
package evseq_pkg;

    localparam int ADDR_W = 16;

    typedef enum logic [1:0] {
        TAKE_NONE = 2'd0,
        TAKE_NMI  = 2'd1,
        TAKE_INT  = 2'd2
    } take_e;

    typedef struct packed {
        logic              granted;
        logic              ie;
        logic              ie_shadow;
        logic              nmi_pend;
        logic              nmi_last;
        logic              halted;
        logic              vec_load;
        logic [ADDR_W-1:0] vec;
    } arb_state_t;

endpackage

// File: rtl/rst_qualify.sv
module rst_qualify #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_core
);
    localparam int HW = (HOLD > 1) ? HOLD - 1 : 1;

    logic [HW-1:0] hist_d, hist_q;
    logic          core_d, core_q;

    always_comb begin
        hist_d = {hist_q[HW-2 >= 0 ? HW-2 : 0 : 0], rst_in};
        if (HW == 1) hist_d = rst_in;
        core_d = rst_in & (&hist_q);
    end

    always_ff @(posedge clk) begin
        hist_q <= hist_d;
        core_q <= core_d;
    end

    assign rst_core = core_q;

endmodule

// File: rtl/mcycle_stub.sv
module mcycle_stub #(
    parameter int CYC_LEN        = 3,
    parameter int MCYC_PER_INSTR = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic wait_n,
    output logic mcycle_end,
    output logic instr_end
);
    localparam int TW = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
    localparam int MW = (MCYC_PER_INSTR > 1) ? $clog2(MCYC_PER_INSTR) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(CYC_LEN - 1);
    localparam logic [MW-1:0] M_LAST = MW'(MCYC_PER_INSTR - 1);

    typedef struct packed {
        logic [TW-1:0] tick;
        logic [MW-1:0] mc;
    } stub_t;

    stub_t s_d, s_q;
    logic  adv;

    always_comb begin
        s_d        = s_q;
        adv        = run & wait_n;
        mcycle_end = adv & (s_q.tick == T_LAST);
        instr_end  = mcycle_end & (s_q.mc == M_LAST);
        if (adv) begin
            s_d.tick = (s_q.tick == T_LAST) ? '0 : s_q.tick + 1'b1;
        end
        if (mcycle_end) begin
            s_d.mc = (s_q.mc == M_LAST) ? '0 : s_q.mc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R10: a low wait input never lets the machine cycle finish
    p_wait_stall_r10: assert property (@(posedge clk) disable iff (rst)
        !wait_n |-> !mcycle_end);

    // R10: the tick counter holds while stalled
    p_wait_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!wait_n && run) |=> $stable(s_q.tick));

endmodule

// File: rtl/event_arbiter.sv
module event_arbiter
    import evseq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
    parameter logic [ADDR_W-1:0] INT_VEC = 16'h0038
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mcycle_end,
    input  logic              instr_end,
    input  logic              busreq_n,
    input  logic              nmi_n,
    input  logic              int_n,
    input  logic              ie_set,
    input  logic              ie_clear,
    input  logic              ie_restore,
    input  logic              halt_op,
    output logic              granted,
    output logic              ie,
    output logic              ie_shadow,
    output logic              halted,
    output logic              vec_load,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam arb_state_t ARB_RST = '{
        granted:   1'b0,
        ie:        1'b0,
        ie_shadow: 1'b0,
        nmi_pend:  1'b0,
        nmi_last:  1'b1,
        halted:    1'b0,
        vec_load:  1'b0,
        vec:       '0
    };

    arb_state_t s_d, s_q;
    logic       take_bus;
    logic       nmi_fall;
    take_e      take;

    always_comb begin
        s_d      = s_q;
        take_bus = mcycle_end & ~busreq_n & ~s_q.granted;
        nmi_fall = s_q.nmi_last & ~nmi_n;

        // fixed priority at the instruction boundary
        take = TAKE_NONE;
        if (instr_end && !take_bus) begin
            if (s_q.nmi_pend)            take = TAKE_NMI;
            else if (s_q.ie && !int_n)   take = TAKE_INT;
        end

        // bus grant and release
        if (s_q.granted) s_d.granted = ~busreq_n;
        else             s_d.granted = take_bus;

        // edge latch for the non-maskable input
        s_d.nmi_last = nmi_n;
        s_d.nmi_pend = (s_q.nmi_pend & (take != TAKE_NMI)) | nmi_fall;

        // enable flip-flop: acceptance overrides software strobes
        if (take != TAKE_NONE) s_d.ie = 1'b0;
        else if (ie_set)       s_d.ie = 1'b1;
        else if (ie_clear)     s_d.ie = 1'b0;
        else if (ie_restore)   s_d.ie = s_q.ie_shadow;

        if (take == TAKE_NMI) s_d.ie_shadow = s_q.ie;

        // halt state
        if (take != TAKE_NONE)         s_d.halted = 1'b0;
        else if (instr_end && halt_op) s_d.halted = 1'b1;

        // restart vector
        s_d.vec_load = (take != TAKE_NONE);
        case (take)
            TAKE_NMI: s_d.vec = NMI_VEC;
            TAKE_INT: s_d.vec = INT_VEC;
            default:  s_d.vec = s_q.vec;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= ARB_RST;
        else     s_q <= s_d;
    end

    assign granted   = s_q.granted;
    assign ie        = s_q.ie;
    assign ie_shadow = s_q.ie_shadow;
    assign halted    = s_q.halted;
    assign vec_load  = s_q.vec_load;
    assign vec_addr  = s_q.vec;

    // R2: a grant only starts from a machine-cycle boundary with request low
    p_grant_boundary_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.granted) |-> $past(mcycle_end && !busreq_n));

    // R3: released request ends the grant one clock later
    p_release_r3: assert property (@(posedge clk) disable iff (rst)
        (s_q.granted && busreq_n) |=> !s_q.granted);

    // R5: only the two legal vectors are ever issued
    p_vec_legal_r5: assert property (@(posedge clk) disable iff (rst)
        s_q.vec_load |-> (s_q.vec == NMI_VEC || s_q.vec == INT_VEC));

    // R7: masked level interrupt gives no acceptance
    p_int_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (instr_end && !s_q.ie && !s_q.nmi_pend) |=> !s_q.vec_load);

    // R8: acceptance always leaves the enable clear
    p_ie_cleared_r8: assert property (@(posedge clk) disable iff (rst)
        s_q.vec_load |-> !s_q.ie);

    // R9: leaving halt outside reset coincides with a vector load
    p_halt_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(s_q.halted)) |-> s_q.vec_load);

endmodule

// File: rtl/irq_bus_sequencer.sv
module irq_bus_sequencer
    import evseq_pkg::*;
#(
    parameter int                CYC_LEN        = 3,
    parameter int                MCYC_PER_INSTR = 2,
    parameter int                RST_HOLD       = 2,
    parameter logic [ADDR_W-1:0] NMI_VEC        = 16'h0066,
    parameter logic [ADDR_W-1:0] INT_VEC        = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_in,
    input  logic              busreq_n,
    input  logic              nmi_n,
    input  logic              int_n,
    input  logic              wait_n,
    input  logic              ie_set,
    input  logic              ie_clear,
    input  logic              ie_restore,
    input  logic              halt_op,
    output logic              busack_n,
    output logic              bus_oe,
    output logic              halt_n,
    output logic              vec_load,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              mcycle_end,
    output logic              instr_end,
    output logic              ie_out,
    output logic              ie_shadow
);
    logic rst_core;
    logic granted;
    logic halted;

    rst_qualify #(.HOLD(RST_HOLD)) u_rst (
        .clk      (clk),
        .rst_in   (rst_in),
        .rst_core (rst_core)
    );

    mcycle_stub #(
        .CYC_LEN        (CYC_LEN),
        .MCYC_PER_INSTR (MCYC_PER_INSTR)
    ) u_stub (
        .clk        (clk),
        .rst        (rst_core),
        .run        (~granted),
        .wait_n     (wait_n),
        .mcycle_end (mcycle_end),
        .instr_end  (instr_end)
    );

    event_arbiter #(
        .NMI_VEC (NMI_VEC),
        .INT_VEC (INT_VEC)
    ) u_arb (
        .clk        (clk),
        .rst        (rst_core),
        .mcycle_end (mcycle_end),
        .instr_end  (instr_end),
        .busreq_n   (busreq_n),
        .nmi_n      (nmi_n),
        .int_n      (int_n),
        .ie_set     (ie_set),
        .ie_clear   (ie_clear),
        .ie_restore (ie_restore),
        .halt_op    (halt_op),
        .granted    (granted),
        .ie         (ie_out),
        .ie_shadow  (ie_shadow),
        .halted     (halted),
        .vec_load   (vec_load),
        .vec_addr   (vec_addr)
    );

    assign busack_n = ~granted;
    assign bus_oe   = ~granted;
    assign halt_n   = ~halted;

    // R2: execution is frozen for the whole grant
    p_frozen_r2: assert property (@(posedge clk) disable iff (rst_core)
        !busack_n |-> !mcycle_end);

    // R11: instruction boundary is always a machine-cycle boundary
    p_instr_on_mcyc_r11: assert property (@(posedge clk) disable iff (rst_core)
        instr_end |-> mcycle_end);

    // R4: no vector load follows a boundary that granted the bus
    p_bus_first_r4: assert property (@(posedge clk) disable iff (rst_core)
        (instr_end && !busreq_n) |=> !vec_load);

endmodule

// File: tb/tb_irq_bus_sequencer.sv
`timescale 1ns/1ps
module tb_irq_bus_sequencer;
    localparam int CYC = 3;
    localparam int MC  = 2;
    localparam logic [15:0] NV = 16'h0066;
    localparam logic [15:0] IV = 16'h0038;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_in = 1'b1, busreq_n = 1'b1, nmi_n = 1'b1, int_n = 1'b1, wait_n = 1'b1;
    logic ie_set = 1'b0, ie_clear = 1'b0, ie_restore = 1'b0, halt_op = 1'b0;
    logic busack_n, bus_oe, halt_n, vec_load, mcycle_end, instr_end, ie_out, ie_shadow;
    logic [15:0] vec_addr;

    irq_bus_sequencer #(.CYC_LEN(CYC), .MCYC_PER_INSTR(MC)) dut (
        .clk(clk), .rst_in(rst_in), .busreq_n(busreq_n), .nmi_n(nmi_n), .int_n(int_n),
        .wait_n(wait_n), .ie_set(ie_set), .ie_clear(ie_clear), .ie_restore(ie_restore),
        .halt_op(halt_op), .busack_n(busack_n), .bus_oe(bus_oe), .halt_n(halt_n),
        .vec_load(vec_load), .vec_addr(vec_addr), .mcycle_end(mcycle_end),
        .instr_end(instr_end), .ie_out(ie_out), .ie_shadow(ie_shadow)
    );

    int n_chk = 0, n_err = 0;
    logic cmp_en = 1'b0;

    // reference model state, written from the requirements
    logic m_rprev = 0, m_rcore = 0, m_gr = 0, m_ie = 0, m_sh = 0, m_pend = 0;
    logic m_nprev = 1, m_halt = 0, m_vl = 0;
    logic [15:0] m_va = 0;
    int m_tick = 0, m_mc = 0;

    function automatic logic f_mend(logic gr, int tick, logic w);
        return !gr && w && (tick == CYC - 1);
    endfunction

    function automatic logic f_iend(logic gr, int tick, int mc, logic w);
        return f_mend(gr, tick, w) && (mc == MC - 1);
    endfunction

    always @(posedge clk) begin : model
        logic mend, iend, tbus, tn, ti;
        mend = f_mend(m_gr, m_tick, wait_n);
        iend = f_iend(m_gr, m_tick, m_mc, wait_n);
        tbus = mend && !busreq_n;
        tn   = iend && !tbus && m_pend;
        ti   = iend && !tbus && !m_pend && m_ie && !int_n;
        if (m_rcore) begin
            m_tick <= 0; m_mc <= 0; m_gr <= 0; m_ie <= 0; m_sh <= 0;
            m_pend <= 0; m_nprev <= 1; m_halt <= 0; m_vl <= 0; m_va <= 0;
        end else begin
            if (!m_gr && wait_n) m_tick <= (m_tick == CYC - 1) ? 0 : m_tick + 1;
            if (mend) m_mc <= (m_mc == MC - 1) ? 0 : m_mc + 1;
            m_gr    <= m_gr ? !busreq_n : tbus;
            m_nprev <= nmi_n;
            m_pend  <= (m_pend && !tn) || (m_nprev && !nmi_n);
            if (tn || ti)      m_ie <= 0;
            else if (ie_set)   m_ie <= 1;
            else if (ie_clear) m_ie <= 0;
            else if (ie_restore) m_ie <= m_sh;
            if (tn) m_sh <= m_ie;
            if (tn || ti)               m_halt <= 0;
            else if (iend && halt_op)   m_halt <= 1;
            m_vl <= tn || ti;
            if (tn) m_va <= NV;
            else if (ti) m_va <= IV;
        end
        m_rcore <= rst_in && m_rprev;
        m_rprev <= rst_in;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 R3 busack_n", {15'd0, busack_n}, {15'd0, !m_gr});
        chk("R2 R3 bus_oe", {15'd0, bus_oe}, {15'd0, !m_gr});
        chk("R9 halt_n", {15'd0, halt_n}, {15'd0, !m_halt});
        chk("R4 R5 R6 R7 vec_load", {15'd0, vec_load}, {15'd0, m_vl});
        if (m_vl) chk("R5 R7 vec_addr", vec_addr, m_va);
        chk("R8 ie_out", {15'd0, ie_out}, {15'd0, m_ie});
        chk("R8 ie_shadow", {15'd0, ie_shadow}, {15'd0, m_sh});
        chk("R10 R11 mcycle_end", {15'd0, mcycle_end}, {15'd0, f_mend(m_gr, m_tick, wait_n)});
        chk("R11 instr_end", {15'd0, instr_end}, {15'd0, f_iend(m_gr, m_tick, m_mc, wait_n)});
    endtask

    // advance one clock, then compare at the falling edge before new drive
    task automatic step();
        @(negedge clk);
        ie_set = 0; ie_clear = 0; ie_restore = 0;
        if (cmp_en) compare_all();
    endtask

    task automatic steps(input int n, output int vl, output int me, output int ie_n);
        vl = 0; me = 0; ie_n = 0;
        for (int i = 0; i < n; i++) begin
            step();
            vl += int'(vec_load);
            me += int'(mcycle_end);
            ie_n += int'(instr_end);
        end
    endtask

    task automatic wait_vec(input int lim, output int seen, output logic [15:0] addr);
        seen = 0; addr = 0;
        for (int i = 0; i < lim && seen == 0; i++) begin
            step();
            if (vec_load) begin seen = 1; addr = vec_addr; end
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : main
        int vl, me, ie_n, seen;
        logic [15:0] a;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        rst_in = 0;
        step(); step();
        cmp_en = 1;

        // R1: reset state
        chk("R1 reset busack_n", {15'd0, busack_n}, 16'd1);
        chk("R1 reset bus_oe", {15'd0, bus_oe}, 16'd1);
        chk("R1 reset halt_n", {15'd0, halt_n}, 16'd1);
        chk("R1 reset ie_out", {15'd0, ie_out}, 16'd0);
        chk("R1 reset vec_load", {15'd0, vec_load}, 16'd0);

        // R11: boundary cadence with no grant and no wait
        steps(30, vl, me, ie_n);
        chk("R11 mcycle count", 16'(me), 16'(30 / CYC));
        chk("R11 instr count", 16'(ie_n), 16'(30 / (CYC * MC)));

        // R8: set enable
        ie_set = 1; step();
        chk("R8 ie_set", {15'd0, ie_out}, 16'd1);

        // R1: single-cycle reset pulse has no effect
        rst_in = 1; step(); rst_in = 0; step(); step(); step();
        chk("R1 short pulse keeps ie", {15'd0, ie_out}, 16'd1);

        // R5 R8: one falling edge, one acceptance, shadow keeps old enable
        nmi_n = 0; step(); nmi_n = 1;
        steps(20, vl, me, ie_n);
        chk("R5 one service per edge", 16'(vl), 16'd1);
        chk("R5 nmi vector", vec_addr, NV);
        chk("R8 ie cleared by nmi", {15'd0, ie_out}, 16'd0);
        chk("R8 shadow copy", {15'd0, ie_shadow}, 16'd1);
        ie_restore = 1; step();
        chk("R8 restore", {15'd0, ie_out}, 16'd1);

        // R7: enabled level interrupt
        int_n = 0;
        wait_vec(20, seen, a);
        chk("R7 int accepted", 16'(seen), 16'd1);
        chk("R7 int vector", a, IV);
        chk("R8 ie cleared by int", {15'd0, ie_out}, 16'd0);
        steps(20, vl, me, ie_n);
        chk("R7 masked int ignored", 16'(vl), 16'd0);

        // R6: both pending at one boundary
        ie_set = 1; step();
        nmi_n = 0; step(); nmi_n = 1;
        wait_vec(20, seen, a);
        chk("R6 nmi first", a, NV);
        int_n = 1;
        steps(6, vl, me, ie_n);

        // R9: halt entered, held, released by interrupt
        halt_op = 1; steps(7, vl, me, ie_n); halt_op = 0;
        chk("R9 halt entered", {15'd0, halt_n}, 16'd0);
        steps(20, vl, me, ie_n);
        chk("R9 halt held", {15'd0, halt_n}, 16'd0);
        nmi_n = 0; step(); nmi_n = 1;
        wait_vec(20, seen, a);
        chk("R9 halt left with vector", {15'd0, halt_n}, 16'd1);

        // R2 R3: bus grant and release
        busreq_n = 0;
        for (int i = 0; i < 10 && busack_n; i++) step();
        chk("R2 grant", {15'd0, busack_n}, 16'd0);
        chk("R2 outputs off", {15'd0, bus_oe}, 16'd0);
        steps(15, vl, me, ie_n);
        chk("R2 frozen", 16'(me), 16'd0);
        busreq_n = 1; step();
        chk("R3 ack released", {15'd0, busack_n}, 16'd1);
        chk("R3 outputs on", {15'd0, bus_oe}, 16'd1);

        // R10: wait stalls
        wait_n = 0; steps(12, vl, me, ie_n); wait_n = 1;
        chk("R10 no boundary in wait", 16'(me), 16'd0);

        // random phase, model compared every cycle
        for (int i = 0; i < 4000; i++) begin
            int op;
            step();
            if ($urandom_range(0, 9) == 0) busreq_n = ~busreq_n;
            nmi_n  = ($urandom_range(0, 40) != 0);
            int_n  = ($urandom_range(0, 2) != 0);
            wait_n = ($urandom_range(0, 7) != 0);
            halt_op = ($urandom_range(0, 15) == 0);
            op = $urandom_range(0, 11);
            ie_set = (op == 0); ie_clear = (op == 1); ie_restore = (op == 2);
        end
        busreq_n = 1; nmi_n = 1; int_n = 1; wait_n = 1; halt_op = 0;
        step();

        // R1: qualified reset clears everything
        ie_set = 1; step();
        rst_in = 1; step(); step(); rst_in = 0; step();
        chk("R1 ie after reset", {15'd0, ie_out}, 16'd0);
        chk("R1 halt_n after reset", {15'd0, halt_n}, 16'd1);
        chk("R1 busack after reset", {15'd0, busack_n}, 16'd1);
        steps(10, vl, me, ie_n);
        finish_run();
    end

endmodule